// File: doc/BRIEF.md
# Dual Multi-Mode Timer/Counter

This block holds two timer/counter channels behind a small byte-wide register window. Each channel advances on one of two sources. The first is an internal machine-cycle tick, which is the clock divided by a parameter (twelve by default). The second is a falling edge on the channel's event pin, after that pin is synchronized. A channel counts only while its run bit is set. When its gate bit is set, it also needs its external enable pin to be high.

Each channel has a two-bit mode. The modes are a 13-bit count built from the high byte over the five low bits of the low byte, a full 16-bit count, and an 8-bit low-byte count that reloads from the high byte when it wraps. Channel 0 has a fourth mode, split mode, in which its two bytes become separate 8-bit counters. The high byte then borrows channel 1's run bit and overflow flag. Overflow flags are sticky until software writes them. Each flag also drives an interrupt request line. The two external-interrupt configuration bit pairs in the control register are stored and read back only.

Top module: `dual_timer_unit`

## Requirements
- R1: After reset all six registers read 0x00, both channels are stopped and both interrupt request outputs are low.
- R2: Register addresses are: 0 = mode, 1 = control, 2 = channel 0 low byte, 3 = channel 0 high byte, 4 = channel 1 low byte, 5 = channel 1 high byte. Each register reads back what was last written to it. The mode register holds channel 1 in bits 7:4 and channel 0 in bits 3:0. Each nibble is {gate, source, mode[1:0]}. The control register holds {flag1, run1, flag0, run0, x1a, x1b, x0a, x0b} from bit 7 down, and the low four bits are storage only.
- R3: When the source bit is 0, a running channel advances once every 12 clocks, with consecutive increments exactly 12 clocks apart.
- R4: When a channel's run bit is 0, its count bytes do not change.
- R5: When the gate bit is 1 and the channel's enable pin is low, the channel holds. When the pin goes high, counting resumes.
- R6: When the source bit is 1, the channel advances by one for each 1-to-0 transition on its event pin, provided each level lasts at least 24 clocks.
- R7: Mode 00 counts 13 bits as {high, low[4:0]}. It sets the flag on the 1FFFh to 0000h wrap and leaves low[7:5] unchanged.
- R8: Mode 01 counts {high, low} as 16 bits and sets the flag on the FFFFh to 0000h wrap.
- R9: In mode 10 only the low byte counts. On its FFh wrap the flag is set and the low byte is loaded from the high byte. The next increment comes 12 clocks later.
- R10: When channel 0 is in mode 11, its low byte sets flag0 on wrap. Its high byte counts internal ticks whenever run1 is set and sets flag1 on wrap.
- R11: While channel 0 is in split mode, channel 1 still counts in its own mode but never sets flag1. A channel 1 placed in mode 11 holds its count.
- R12: A flag stays set until software writes the control register. A software write to the control register or to a count byte wins over a hardware update in the same cycle. Each interrupt request output equals its flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data, combinational from regAddr |
| evtIn | input | 2 | Per-channel external event pins |
| gateIn | input | 2 | Per-channel external enable pins |
| irqReq | output | 2 | Per-channel interrupt requests (flag copies) |

## Verification
The assertions assume that a stretch with no register write reflects hardware behaviour only. Each property therefore excludes any cycle with a write to the mode register or to the bytes it watches. The assertions also assume that the run bits and the mode register change only through writes. They take the reset values from the asynchronous reset. The stimulus writes registers only in deliberate single-cycle strokes between observation windows. It holds each event-pin level for at least two machine cycles, so that no edge falls between samples.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] ADDR_MODE = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_LO0  = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_HI0  = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_LO1  = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_HI1  = 3'd5;

  // control register bit positions
  localparam int BIT_FLAG1 = 7;
  localparam int BIT_RUN1  = 6;
  localparam int BIT_FLAG0 = 5;
  localparam int BIT_RUN0  = 4;

  typedef enum logic [1:0] {
    MODE13     = 2'b00,
    MODE16     = 2'b01,
    MODERELOAD = 2'b10,
    MODESPLIT  = 2'b11
  } tmrMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic step0;    // channel 0 main count advance
    logic step0Hi;  // channel 0 high byte advance (split mode)
    logic step1;    // channel 1 count advance
  } tmrStrobes_t;

  typedef struct packed {
    logic [7:0] lo;
    logic [7:0] hi;
    logic       ovf;
  } cntNext_t;

  function automatic cntNext_t advanceCount(input logic [1:0] mode,
                                            input logic [7:0] lo,
                                            input logic [7:0] hi,
                                            input logic step);
    cntNext_t r;
    logic [13:0] c13;
    logic [16:0] c16;
    logic [8:0]  c8;
    r.lo  = lo;
    r.hi  = hi;
    r.ovf = 1'b0;
    c13 = {1'b0, hi, lo[4:0]} + 14'd1;
    c16 = {1'b0, hi, lo} + 17'd1;
    c8  = {1'b0, lo} + 9'd1;
    if (step) begin
      case (mode)
        MODE13: begin
          r.hi  = c13[12:5];
          r.lo  = {lo[7:5], c13[4:0]};
          r.ovf = c13[13];
        end
        MODE16: begin
          r.hi  = c16[15:8];
          r.lo  = c16[7:0];
          r.ovf = c16[16];
        end
        MODERELOAD: begin
          if (lo == 8'hFF) begin
            r.lo  = hi;
            r.ovf = 1'b1;
          end else begin
            r.lo = c8[7:0];
          end
        end
        default: begin
          r.lo  = c8[7:0];
          r.ovf = c8[8];
        end
      endcase
    end
    return r;
  endfunction
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int PRESCALE = 12,
  parameter int CHANNELS = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [4*CHANNELS-1:0] modeQ,
  input  logic [CHANNELS-1:0] runBits,
  input  logic [CHANNELS-1:0] evtIn,
  input  logic [CHANNELS-1:0] gateIn,
  output tmrStrobes_t         strobes
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PW-1:0] PLAST = PW'(PRESCALE - 1);

  logic [PW-1:0] preCnt;
  logic          tick;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) preCnt <= '0;
    else if (preCnt == PLAST) preCnt <= '0;
    else preCnt <= preCnt + PW'(1);
  end
  assign tick = (preCnt == PLAST);

  logic [CHANNELS-1:0] chanEn;
  logic [CHANNELS-1:0] chanSrc;

  for (genvar i = 0; i < CHANNELS; i++) begin : g_chan
    logic [SYNC_STAGES-1:0] syncPipe;
    logic                   sampled;
    logic                   fallSeen;
    logic                   gateBit, srcBit;

    assign gateBit = modeQ[4*i+3];
    assign srcBit  = modeQ[4*i+2];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncPipe <= '0;
        sampled  <= 1'b0;
      end else begin
        syncPipe <= {syncPipe[SYNC_STAGES-2:0], evtIn[i]};
        if (tick) sampled <= syncPipe[SYNC_STAGES-1];
      end
    end

    assign fallSeen   = tick && sampled && !syncPipe[SYNC_STAGES-1];
    assign chanSrc[i] = srcBit ? fallSeen : tick;
    assign chanEn[i]  = runBits[i] && (!gateBit || gateIn[i]);
  end

  logic [1:0] mode0, mode1;
  assign mode0 = modeQ[1:0];
  assign mode1 = modeQ[5:4];

  always_comb begin
    strobes.step0   = chanEn[0] && chanSrc[0];
    strobes.step0Hi = (mode0 == MODESPLIT) && runBits[1] && tick;
    strobes.step1   = chanEn[1] && chanSrc[1] && (mode1 != MODESPLIT);
  end
endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [7:0]        regWdata,
  input  tmrStrobes_t       strobes,
  output logic [7:0]        modeQ,
  output logic [7:0]        ctrlQ,
  output logic [7:0]        lo0,
  output logic [7:0]        hi0,
  output logic [7:0]        lo1,
  output logic [7:0]        hi1,
  output logic [7:0]        regRdata,
  output logic [1:0]        irqReq
);
  logic wrMode, wrCtrl, wrLo0, wrHi0, wrLo1, wrHi1;
  assign wrMode = regWe && (regAddr == ADDR_MODE);
  assign wrCtrl = regWe && (regAddr == ADDR_CTRL);
  assign wrLo0  = regWe && (regAddr == ADDR_LO0);
  assign wrHi0  = regWe && (regAddr == ADDR_HI0);
  assign wrLo1  = regWe && (regAddr == ADDR_LO1);
  assign wrHi1  = regWe && (regAddr == ADDR_HI1);

  logic     split0;
  cntNext_t next0, next1;
  logic [8:0] hiSum;
  logic     setFlag0, setFlag1;

  assign split0 = (modeQ[1:0] == MODESPLIT);
  assign next0  = advanceCount(modeQ[1:0], lo0, hi0, strobes.step0);
  assign next1  = advanceCount(modeQ[5:4], lo1, hi1, strobes.step1);
  assign hiSum  = {1'b0, hi0} + 9'd1;

  assign setFlag0 = next0.ovf;
  assign setFlag1 = split0 ? (strobes.step0Hi && hiSum[8]) : next1.ovf;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ <= '0;
      ctrlQ <= '0;
      lo0   <= '0;
      hi0   <= '0;
      lo1   <= '0;
      hi1   <= '0;
    end else begin
      if (wrMode) modeQ <= regWdata;

      if (wrCtrl) ctrlQ <= regWdata;
      else begin
        if (setFlag0) ctrlQ[BIT_FLAG0] <= 1'b1;
        if (setFlag1) ctrlQ[BIT_FLAG1] <= 1'b1;
      end

      if (wrLo0) lo0 <= regWdata;
      else lo0 <= next0.lo;

      if (wrHi0) hi0 <= regWdata;
      else if (split0 && strobes.step0Hi) hi0 <= hiSum[7:0];
      else hi0 <= next0.hi;

      if (wrLo1) lo1 <= regWdata;
      else lo1 <= next1.lo;

      if (wrHi1) hi1 <= regWdata;
      else hi1 <= next1.hi;
    end
  end

  always_comb begin
    case (regAddr)
      ADDR_MODE: regRdata = modeQ;
      ADDR_CTRL: regRdata = ctrlQ;
      ADDR_LO0:  regRdata = lo0;
      ADDR_HI0:  regRdata = hi0;
      ADDR_LO1:  regRdata = lo1;
      ADDR_HI1:  regRdata = hi1;
      default:   regRdata = 8'h00;
    endcase
  end

  assign irqReq = {ctrlQ[BIT_FLAG1], ctrlQ[BIT_FLAG0]};
endmodule

// File: rtl/dual_timer_unit.sv
module dual_timer_unit
  import tmr_pkg::*;
#(
  parameter int PRESCALE = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [7:0]        regWdata,
  output logic [7:0]        regRdata,
  input  logic [1:0]        evtIn,
  input  logic [1:0]        gateIn,
  output logic [1:0]        irqReq
);
  tmrStrobes_t strobes;
  logic [7:0]  modeQ, ctrlQ, lo0, hi0, lo1, hi1;

  tmr_ctrl #(
    .PRESCALE(PRESCALE),
    .CHANNELS(2),
    .SYNC_STAGES(2)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .modeQ   (modeQ),
    .runBits ({ctrlQ[BIT_RUN1], ctrlQ[BIT_RUN0]}),
    .evtIn   (evtIn),
    .gateIn  (gateIn),
    .strobes (strobes)
  );

  tmr_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .regWe    (regWe),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .strobes  (strobes),
    .modeQ    (modeQ),
    .ctrlQ    (ctrlQ),
    .lo0      (lo0),
    .hi0      (hi0),
    .lo1      (lo1),
    .hi1      (hi1),
    .regRdata (regRdata),
    .irqReq   (irqReq)
  );
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
  import tmr_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              regWe,
  input logic [ADDR_W-1:0] regAddr,
  input logic [7:0]        modeReg,
  input logic [7:0]        ctrlReg,
  input logic [7:0]        lo0,
  input logic [7:0]        hi0,
  input logic [7:0]        lo1,
  input logic [7:0]        hi1
);
  logic wrMode, wrCtrl, wrLo0, wrHi0, wrLo1, wrHi1;
  assign wrMode = regWe && (regAddr == ADDR_MODE);
  assign wrCtrl = regWe && (regAddr == ADDR_CTRL);
  assign wrLo0  = regWe && (regAddr == ADDR_LO0);
  assign wrHi0  = regWe && (regAddr == ADDR_HI0);
  assign wrLo1  = regWe && (regAddr == ADDR_LO1);
  assign wrHi1  = regWe && (regAddr == ADDR_HI1);

  // R12: flag0 stays set without a control write
  p_flag_sticky_r12: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlReg[BIT_FLAG0] && !wrCtrl) |=> ctrlReg[BIT_FLAG0])
    else $error("flag0 dropped without a control write");

  // R4: stopped channel 0 holds
  p_hold_stopped_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlReg[BIT_RUN0] && modeReg[1:0] != 2'b11 && !wrLo0 && !wrHi0 && !wrMode)
      |=> ($stable(lo0) && $stable(hi0)))
    else $error("stopped channel 0 changed");

  // R3: 16-bit count moves by at most one per cycle
  p_step16_r3: assert property (@(posedge clk) disable iff (!rstN)
    (modeReg[1:0] == 2'b01 && !wrLo0 && !wrHi0 && !wrMode)
      |=> (({hi0, lo0} == $past({hi0, lo0})) || ({hi0, lo0} == $past({hi0, lo0}) + 16'd1)))
    else $error("16-bit count jumped");

  // R8: flag0 rises in 16-bit mode only together with a wrap to zero
  p_wrap16_r8: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(ctrlReg[BIT_FLAG0]) && $past(!wrCtrl && !wrLo0 && !wrHi0 && !wrMode && modeReg[1:0] == 2'b01))
      |-> ({hi0, lo0} == 16'h0000))
    else $error("flag0 rose without 16-bit wrap");

  // R9: reload mode leaves FFh only by loading the high byte
  p_reload_r9: assert property (@(posedge clk) disable iff (!rstN)
    (modeReg[1:0] == 2'b10 && lo0 == 8'hFF && !wrLo0 && !wrHi0 && !wrMode)
      |=> (lo0 == 8'hFF || lo0 == $past(hi0)))
    else $error("reload value wrong");

  // R11: channel 1 in mode 11 holds
  p_ch1_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (modeReg[5:4] == 2'b11 && !wrLo1 && !wrHi1 && !wrMode)
      |=> ($stable(lo1) && $stable(hi1)))
    else $error("channel 1 moved in mode 11");
endmodule

bind dual_timer_unit tmr_checker u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .regWe   (regWe),
  .regAddr (regAddr),
  .modeReg (modeQ),
  .ctrlReg (ctrlQ),
  .lo0     (lo0),
  .hi0     (hi0),
  .lo1     (lo1),
  .hi1     (hi1)
);

// File: tb/dual_timer_unit_test.sv
module dual_timer_unit_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWe = 1'b0;
  logic [2:0] regAddr = 3'd0;
  logic [7:0] regWdata = 8'h00;
  logic [7:0] regRdata;
  logic [1:0] evtIn = 2'b00;
  logic [1:0] gateIn = 2'b00;
  logic [1:0] irqReq;

  int testsRun = 0;
  int testsFailed = 0;
  int cycles = 0;

  dual_timer_unit uut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .evtIn(evtIn),
    .gateIn(gateIn), .irqReq(irqReq)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      testsFailed++;
      $display("FAIL watchdog: run hung, got %0d cycles expected < 150000", cycles);
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    testsRun++;
    if (got !== exp) begin
      testsFailed++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdata;
  endtask

  // polls control each cycle until bit is set; returns 1 if seen
  task automatic waitFlag(input int bitPos, input int limit, output logic seen);
    logic [7:0] d;
    seen = 1'b0;
    for (int i = 0; i < limit && !seen; i++) begin
      rd(3'd1, d);
      if (d[bitPos]) seen = 1'b1;
    end
  endtask

  task automatic testReset;
    logic [7:0] d;
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), d);
      check($sformatf("R1 reg %0d after reset", a), {8'h0, d}, 16'h0000);
    end
    check("R1 irq after reset", {14'h0, irqReq}, 16'h0000);
    repeat (30) @(negedge clk);
    rd(3'd2, d);
    check("R1 stopped after reset", {8'h0, d}, 16'h0000);
  endtask

  task automatic testRegs;
    logic [7:0] d;
    wr(3'd0, 8'hA6); rd(3'd0, d); check("R2 mode readback", {8'h0, d}, 16'h00A6);
    wr(3'd0, 8'h00);
    wr(3'd1, 8'h0F); rd(3'd1, d); check("R2 ctrl storage bits", {8'h0, d}, 16'h000F);
    check("R2 storage bits raise no irq", {14'h0, irqReq}, 16'h0000);
    wr(3'd2, 8'h11); wr(3'd3, 8'h22); wr(3'd4, 8'h33); wr(3'd5, 8'h44);
    rd(3'd2, d); check("R2 lo0", {8'h0, d}, 16'h0011);
    rd(3'd3, d); check("R2 hi0", {8'h0, d}, 16'h0022);
    rd(3'd4, d); check("R2 lo1", {8'h0, d}, 16'h0033);
    rd(3'd5, d); check("R2 hi1", {8'h0, d}, 16'h0044);
    wr(3'd1, 8'h00);
  endtask

  task automatic testStop;
    logic [7:0] d;
    wr(3'd0, 8'h11); wr(3'd2, 8'h5A); wr(3'd4, 8'hC3);
    repeat (40) @(negedge clk);
    rd(3'd2, d); check("R4 ch0 held", {8'h0, d}, 16'h005A);
    rd(3'd4, d); check("R4 ch1 held", {8'h0, d}, 16'h00C3);
  endtask

  task automatic testPeriod;
    logic [7:0] d, first, prev;
    logic moved;
    wr(3'd0, 8'h01); wr(3'd2, 8'h00); wr(3'd3, 8'h00);
    wr(3'd1, 8'h10);
    rd(3'd2, first);
    moved = 1'b0;
    for (int i = 0; i < 20 && !moved; i++) begin
      rd(3'd2, d);
      if (d != first) moved = 1'b1;
    end
    check("R3 count started", {15'h0, moved}, 16'h0001);
    prev = d;
    for (int i = 0; i < 11; i++) rd(3'd2, d);
    check("R3 still same after 11 clocks", {8'h0, d}, {8'h0, prev});
    rd(3'd2, d);
    check("R3 increments on 12th clock", {8'h0, d}, {8'h0, prev + 8'd1});
    wr(3'd1, 8'h00);
  endtask

  task automatic testGate;
    logic [7:0] d;
    gateIn = 2'b00;
    wr(3'd0, 8'h09); wr(3'd2, 8'h00); wr(3'd3, 8'h00);
    wr(3'd1, 8'h10);
    repeat (60) @(negedge clk);
    rd(3'd2, d); check("R5 gated low holds", {8'h0, d}, 16'h0000);
    gateIn = 2'b01;
    repeat (40) @(negedge clk);
    rd(3'd2, d); check("R5 gate high counts", {15'h0, d >= 8'd2}, 16'h0001);
    wr(3'd1, 8'h00);
    gateIn = 2'b00;
  endtask

  task automatic testEvents;
    logic [7:0] d;
    evtIn = 2'b00;
    wr(3'd0, 8'h05); wr(3'd2, 8'h00); wr(3'd3, 8'h00);
    wr(3'd1, 8'h10);
    repeat (40) @(negedge clk);
    for (int p = 0; p < 3; p++) begin
      evtIn[0] = 1'b1; repeat (30) @(negedge clk);
      evtIn[0] = 1'b0; repeat (30) @(negedge clk);
    end
    repeat (30) @(negedge clk);
    rd(3'd2, d); check("R6 three falling edges", {8'h0, d}, 16'h0003);
    rd(3'd3, d); check("R6 high byte", {8'h0, d}, 16'h0000);
    wr(3'd1, 8'h00);
  endtask

  task automatic testMode13;
    logic [7:0] d; logic seen;
    wr(3'd0, 8'h00); wr(3'd3, 8'hFF); wr(3'd2, 8'hFF);
    wr(3'd1, 8'h10);
    waitFlag(5, 40, seen);
    check("R7 flag on 1FFF wrap", {15'h0, seen}, 16'h0001);
    rd(3'd3, d); check("R7 high after wrap", {8'h0, d}, 16'h0000);
    rd(3'd2, d); check("R7 low keeps upper bits", {8'h0, d}, 16'h00E0);
    wr(3'd1, 8'h00);
  endtask

  task automatic testMode16;
    logic [7:0] d; logic seen;
    wr(3'd0, 8'h01); wr(3'd3, 8'hFF); wr(3'd2, 8'hFE);
    wr(3'd1, 8'h10);
    rd(3'd1, d); check("R8 no flag before wrap", {8'h0, d}, 16'h0010);
    waitFlag(5, 40, seen);
    check("R8 flag on FFFF wrap", {15'h0, seen}, 16'h0001);
    rd(3'd2, d); check("R8 low after wrap", {8'h0, d}, 16'h0000);
    rd(3'd3, d); check("R8 high after wrap", {8'h0, d}, 16'h0000);
    check("R12 irq0 follows flag", {14'h0, irqReq}, 16'h0001);
    repeat (30) @(negedge clk);
    check("R12 flag sticky", {14'h0, irqReq}, 16'h0001);
    wr(3'd1, 8'h00);
    rd(3'd1, d); check("R12 write clears flag", {8'h0, d}, 16'h0000);
    check("R12 irq cleared", {14'h0, irqReq}, 16'h0000);
  endtask

  task automatic testReload;
    logic [7:0] d; logic seen;
    wr(3'd0, 8'h02); wr(3'd3, 8'h80); wr(3'd2, 8'hFE);
    wr(3'd1, 8'h10);
    waitFlag(5, 40, seen);
    check("R9 flag on FF wrap", {15'h0, seen}, 16'h0001);
    rd(3'd2, d); check("R9 reloaded", {8'h0, d}, 16'h0080);
    repeat (9) @(negedge clk);
    rd(3'd2, d); check("R9 holds until next tick", {8'h0, d}, 16'h0080);
    rd(3'd2, d); check("R9 continues from reload", {8'h0, d}, 16'h0081);
    rd(3'd3, d); check("R9 high byte untouched", {8'h0, d}, 16'h0080);
    wr(3'd1, 8'h00);
  endtask

  task automatic testSplit;
    logic [7:0] d; logic seen;
    wr(3'd0, 8'h03); wr(3'd2, 8'hFF); wr(3'd3, 8'hFE);
    wr(3'd1, 8'h50);
    waitFlag(5, 40, seen);
    check("R10 low byte sets flag0", {15'h0, seen}, 16'h0001);
    rd(3'd1, d); check("R10 flag1 not yet", {15'h0, d[7]}, 16'h0000);
    waitFlag(7, 20, seen);
    check("R10 high byte sets flag1", {15'h0, seen}, 16'h0001);
    check("R10 both irqs", {14'h0, irqReq}, 16'h0003);
    wr(3'd1, 8'h00);
    // channel 1 still counts in split mode but raises no flag
    wr(3'd0, 8'h13); wr(3'd2, 8'h00); wr(3'd3, 8'h00);
    wr(3'd4, 8'hFF); wr(3'd5, 8'hFF);
    wr(3'd1, 8'h40);
    repeat (30) @(negedge clk);
    rd(3'd5, d); check("R11 ch1 wrapped in split", {8'h0, d}, 16'h0000);
    rd(3'd1, d); check("R11 no flag from ch1", {8'h0, d}, 16'h0040);
    wr(3'd1, 8'h00);
  endtask

  task automatic testCh1Mode3;
    logic [7:0] d;
    wr(3'd0, 8'h30); wr(3'd4, 8'h12); wr(3'd5, 8'h34);
    wr(3'd1, 8'h40);
    repeat (60) @(negedge clk);
    rd(3'd4, d); check("R11 ch1 mode3 lo held", {8'h0, d}, 16'h0012);
    rd(3'd5, d); check("R11 ch1 mode3 hi held", {8'h0, d}, 16'h0034);
    wr(3'd1, 8'h00);
  endtask

  task automatic testPriority;
    logic [7:0] d;
    wr(3'd0, 8'h01); wr(3'd3, 8'h00);
    wr(3'd1, 8'h10);
    @(negedge clk);
    regWe = 1'b1; regAddr = 3'd2; regWdata = 8'h55;
    repeat (30) @(negedge clk);
    regWe = 1'b0;
    #1 d = regRdata;
    check("R12 write wins over count", {8'h0, d}, 16'h0055);
    rd(3'd3, d); check("R12 high unchanged", {8'h0, d}, 16'h0000);
    wr(3'd1, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testRegs();
    testStop();
    testPeriod();
    testGate();
    testEvents();
    testMode13();
    testMode16();
    testReload();
    testSplit();
    testCh1Mode3();
    testPriority();
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule